// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block paces a successive-approximation converter. It takes a programmed operating mode, an enable bit, a channel code, a clock divider, a continuous-mode rate and a settle-time field. From these it produces a sample tick, waits a settle interval after power-up, and then raises conversion requests in the pattern the mode selects. The converter is an external handshake: the block holds a request until the converter answers with a done pulse and a raw code. The block then presents that code with a one-cycle valid strobe.

There are four modes, encoded on `mode_i` as 0 = powered down, 1 = single step, 2 = software triggered and 3 = free running. Before each conversion the block waits either 4 or 8 sample ticks so the input can be acquired. A busy flag covers that acquisition wait and the conversion itself. If the enable is dropped or the mode is set to powered down, all activity stops and the next enable starts a fresh settle interval.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `conv_req_o`, `data_valid_o` and `settled_o` are all low.
- R2: While running, `sample_tick_o` pulses once every 2*(`div_i`+1) clock cycles. When `fast_i` is set, it pulses on every cycle and `div_i` has no effect.
- R3: The block is running when `en_i` is high and `mode_i` is not 0. When the block starts running, `settled_o` stays low for (`settle_i`+1)*8 sample ticks and rises at the edge that consumes the last of those ticks.
- R4: Each conversion is preceded by an acquisition wait of 4 ticks, or 8 ticks when `long_wait_i` is set. In single-step and free-running modes, the first request rises P*((`settle_i`+1)*8+1+W) clock edges after the first edge at which the block runs, where P is the tick spacing in cycles and W is the wait length in ticks.
- R5: In free-running mode (`mode_i`=3), successive rising edges of `conv_req_o` are exactly (16+`rate_i`) sample ticks apart.
- R6: In single-step mode (`mode_i`=1), exactly one conversion runs per start. After it, `busy_o` is low and no further request appears until the block stops and starts again.
- R7: In software mode (`mode_i`=2), no conversion runs without a `sw_start_i` pulse. Each pulse leads to one conversion. A pulse that arrives while a conversion is under way is remembered and starts exactly one more conversion.
- R8: `conv_req_o` stays high until `conv_done_i` is seen. `busy_o` is high for the whole acquisition wait and for every cycle in which `conv_req_o` is high.
- R9: When `conv_done_i` is seen while `conv_req_o` is high, `data_o` takes `conv_code_i` and `data_valid_o` is high for exactly the next cycle. Each accepted code gives exactly one valid pulse.
- R10: `conv_chan_o` takes `chan_i` when an acquisition wait starts and holds that value while a request is up. `conv_digital_o` is 1 when `conv_chan_o` is below 6 and 0 otherwise.
- R11: Dropping `en_i`, or setting `mode_i` to 0, clears `busy_o`, `conv_req_o` and `settled_o` at the next edge and suppresses any valid pulse. A later start repeats the full settle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 0 off, 1 single, 2 software, 3 free running |
| en_i | input | 1 | Converter enable |
| chan_i | input | 4 | Channel select |
| div_i | input | 6 | Sample tick divider |
| fast_i | input | 1 | Divider bypass, tick on every cycle |
| rate_i | input | 6 | Free-running period extension in ticks |
| settle_i | input | 3 | Settle interval, in units of 8 ticks, minus one |
| long_wait_i | input | 1 | Acquisition wait: 0 = 4 ticks, 1 = 8 ticks |
| sw_start_i | input | 1 | Software conversion trigger pulse |
| conv_done_i | input | 1 | Converter done pulse |
| conv_code_i | input | 12 | Raw code from converter |
| conv_req_o | output | 1 | Conversion request to converter |
| conv_chan_o | output | 4 | Channel of the current conversion |
| conv_digital_o | output | 1 | Current channel is a digital one |
| sample_tick_o | output | 1 | Sample clock enable |
| busy_o | output | 1 | Acquisition or conversion in progress |
| settled_o | output | 1 | Settle interval complete |
| data_valid_o | output | 1 | One-cycle strobe for a new code |
| data_o | output | 12 | Last accepted code |

## Verification
The hardest case to reach is an abort that lands inside the acquisition wait of a free-running stream. At that point no request is visible, but the period counter and the wait counter are both mid-count. The stimulus polls for `busy_o` high with `conv_req_o` low and only then drops the enable, or later the mode. It then confirms that no valid pulse follows and that the next start again takes the full settle and wait time, measured to the exact cycle. A second case is a software trigger that arrives while a request is outstanding. The bench fires that trigger only after it has seen the request rise, and then counts the conversions that follow.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STEP = 2'd1,
    MODE_SW   = 2'd2,
    MODE_CONT = 2'd3
  } seq_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_IDLE,
    ST_WAIT,
    ST_CONV,
    ST_GAP,
    ST_HOLD
  } seq_state_e;

  localparam int unsigned PERIOD_BASE = 16;
  localparam int unsigned WAIT_SHORT  = 4;
  localparam int unsigned WAIT_LONG   = 8;

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fast_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  // 2*(div+1)-1
  assign lim  = {div_i, 1'b1};
  assign wrap = cnt_q >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || fast_i || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (fast_i || wrap);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned RATE_W   = 6,
  parameter int unsigned SETTLE_W = 3,
  parameter int unsigned CHAN_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                tick_i,
  input  seq_mode_e           mode_i,
  input  logic                sw_start_i,
  input  logic                long_wait_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CHAN_W-1:0]   chan_i,
  input  logic                conv_done_i,
  output seq_state_e          state_o,
  output logic [CHAN_W-1:0]   chan_o
);

  localparam int unsigned TCNT_W = (SETTLE_W + 3 > 4) ? SETTLE_W + 3 : 4;
  localparam int unsigned PCNT_W = RATE_W + 2;

  seq_state_e          state_q;
  logic [TCNT_W-1:0]   tcnt_q;
  logic [PCNT_W-1:0]   pcnt_q;
  logic [PCNT_W-1:0]   pcnt_inc;
  logic [CHAN_W-1:0]   chan_q;
  logic                sw_pend_q;
  logic [TCNT_W-1:0]   settle_lim;
  logic [TCNT_W-1:0]   wait_lim;
  logic [PCNT_W-1:0]   per_lim;
  logic                go;

  assign settle_lim = TCNT_W'({settle_i, 3'b111});
  assign wait_lim   = long_wait_i ? TCNT_W'(WAIT_LONG - 1) : TCNT_W'(WAIT_SHORT - 1);
  assign per_lim    = PCNT_W'(rate_i) + PCNT_W'(PERIOD_BASE - 1);
  assign pcnt_inc   = (pcnt_q == '1) ? pcnt_q : pcnt_q + 1'b1;

  always_comb begin
    unique case (mode_i)
      MODE_STEP, MODE_CONT: go = 1'b1;
      MODE_SW:              go = sw_pend_q;
      default:              go = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      tcnt_q    <= '0;
      pcnt_q    <= '0;
      chan_q    <= '0;
      sw_pend_q <= 1'b0;
    end else if (!active_i) begin
      state_q   <= ST_OFF;
      tcnt_q    <= '0;
      pcnt_q    <= '0;
      sw_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_q <= ST_SETTLE;
          tcnt_q  <= '0;
        end
        ST_SETTLE: begin
          if (tick_i) begin
            if (tcnt_q == settle_lim) begin
              state_q <= ST_IDLE;
              tcnt_q  <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_IDLE: begin
          if (tick_i && go) begin
            state_q   <= ST_WAIT;
            tcnt_q    <= '0;
            pcnt_q    <= '0;
            chan_q    <= chan_i;
            sw_pend_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (tick_i) begin
            pcnt_q <= pcnt_inc;
            if (tcnt_q == wait_lim) begin
              state_q <= ST_CONV;
              tcnt_q  <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick_i) pcnt_q <= pcnt_inc;
          if (conv_done_i) begin
            unique case (mode_i)
              MODE_STEP: state_q <= ST_HOLD;
              MODE_CONT: state_q <= ST_GAP;
              default:   state_q <= ST_IDLE;
            endcase
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            if (mode_i != MODE_CONT) begin
              state_q <= ST_IDLE;
            end else if (pcnt_q >= per_lim) begin
              state_q <= ST_WAIT;
              tcnt_q  <= '0;
              pcnt_q  <= '0;
              chan_q  <= chan_i;
            end else begin
              pcnt_q <= pcnt_inc;
            end
          end
        end
        ST_HOLD: begin
          if (mode_i != MODE_STEP) state_q <= ST_IDLE;
        end
        default: state_q <= ST_OFF;
      endcase
      // a trigger seen in any running state is kept until taken
      if (sw_start_i) sw_pend_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign chan_o  = chan_q;

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] data_o
);

  logic              valid_q;
  logic [CODE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= accept_i;
      if (accept_i) data_q <= code_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_W    = 6,
  parameter int unsigned RATE_W   = 6,
  parameter int unsigned SETTLE_W = 3,
  parameter int unsigned CHAN_W   = 4,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned NUM_DIG  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                en_i,
  input  logic [CHAN_W-1:0]   chan_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                fast_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                long_wait_i,
  input  logic                sw_start_i,
  input  logic                conv_done_i,
  input  logic [CODE_W-1:0]   conv_code_i,
  output logic                conv_req_o,
  output logic [CHAN_W-1:0]   conv_chan_o,
  output logic                conv_digital_o,
  output logic                sample_tick_o,
  output logic                busy_o,
  output logic                settled_o,
  output logic                data_valid_o,
  output logic [CODE_W-1:0]   data_o
);

  seq_mode_e         mode;
  seq_state_e        state;
  logic              active;
  logic              run;
  logic              tick;
  logic              accept;
  logic [CHAN_W-1:0] chan_q;

  assign mode   = seq_mode_e'(mode_i);
  assign active = en_i && (mode != MODE_OFF);
  assign run    = active && (state != ST_OFF);

  adc_seq_tick #(
    .DIV_W (DIV_W)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .fast_i (fast_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  adc_seq_fsm #(
    .RATE_W   (RATE_W),
    .SETTLE_W (SETTLE_W),
    .CHAN_W   (CHAN_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .tick_i      (tick),
    .mode_i      (mode),
    .sw_start_i  (sw_start_i),
    .long_wait_i (long_wait_i),
    .rate_i      (rate_i),
    .settle_i    (settle_i),
    .chan_i      (chan_i),
    .conv_done_i (conv_done_i),
    .state_o     (state),
    .chan_o      (chan_q)
  );

  assign accept = active && (state == ST_CONV) && conv_done_i;

  adc_seq_capture #(
    .CODE_W (CODE_W)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .code_i   (conv_code_i),
    .valid_o  (data_valid_o),
    .data_o   (data_o)
  );

  assign conv_req_o     = (state == ST_CONV);
  assign busy_o         = (state == ST_WAIT) || (state == ST_CONV);
  assign settled_o      = (state != ST_OFF) && (state != ST_SETTLE);
  assign conv_chan_o    = chan_q;
  assign conv_digital_o = chan_q < CHAN_W'(NUM_DIG);
  assign sample_tick_o  = tick;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned CHAN_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              en_i,
  input logic              fast_i,
  input logic              conv_done_i,
  input logic              conv_req_o,
  input logic              busy_o,
  input logic              data_valid_o,
  input logic              sample_tick_o,
  input logic [CHAN_W-1:0] conv_chan_o
);

  a_r8_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy_o);

  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i && en_i && mode_i != 2'd0) |=> conv_req_o);

  a_r11_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || mode_i == 2'd0) |=> (!busy_o && !conv_req_o));

  a_r9_done_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && conv_done_i && en_i && mode_i != 2'd0) |=> data_valid_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  a_r10_chan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> (!conv_req_o || $stable(conv_chan_o)));

  a_r2_fast_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && busy_o && en_i && mode_i != 2'd0) |-> sample_tick_o);

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .en_i          (en_i),
  .fast_i        (fast_i),
  .conv_done_i   (conv_done_i),
  .conv_req_o    (conv_req_o),
  .busy_o        (busy_o),
  .data_valid_o  (data_valid_o),
  .sample_tick_o (sample_tick_o),
  .conv_chan_o   (conv_chan_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        en = 1'b0;
  logic [3:0]  chan = 4'd0;
  logic [5:0]  div = 6'd0;
  logic        fast = 1'b0;
  logic [5:0]  rate = 6'd0;
  logic [2:0]  settle = 3'd0;
  logic        long_wait = 1'b0;
  logic        sw_start = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_code = 12'd0;
  logic        conv_req, conv_digital, tick, busy, settled, dvalid;
  logic [3:0]  conv_chan;
  logic [11:0] dout;

  always #4 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_i(en), .chan_i(chan),
    .div_i(div), .fast_i(fast), .rate_i(rate), .settle_i(settle),
    .long_wait_i(long_wait), .sw_start_i(sw_start), .conv_done_i(conv_done),
    .conv_code_i(conv_code), .conv_req_o(conv_req), .conv_chan_o(conv_chan),
    .conv_digital_o(conv_digital), .sample_tick_o(tick), .busy_o(busy),
    .settled_o(settled), .data_valid_o(dvalid), .data_o(dout)
  );

  int checks = 0, errors = 0, cyc = 0;
  int rises = 0, last_rise = 0, prev_rise = 0;
  int last_tick = 0, tick_gap = 0, valid_cnt = 0;
  int r8_bad = 0, dbl_valid = 0, c0 = 0, base = 0;
  bit req_prev = 0, valid_prev = 0, finished = 0;
  logic [3:0]  cur_chan = 4'd0;
  logic [11:0] code_next = 12'h05a;
  logic [15:0] expq [$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_rises(input int n);
    for (int t = 0; t < 5000 && rises < n; t++) @(negedge clk);
  endtask

  task automatic wait_acq();
    for (int t = 0; t < 5000 && !(busy && !conv_req); t++) @(negedge clk);
  endtask

  always @(posedge clk) cyc++;

  // monitor: edges, ticks and scoreboard compare
  always @(negedge clk) begin
    if (tick) begin
      tick_gap  = cyc - last_tick;
      last_tick = cyc;
    end
    if (conv_req && !req_prev) begin
      rises++;
      prev_rise = last_rise;
      last_rise = cyc;
    end
    if (conv_req && !busy) r8_bad++;
    req_prev = conv_req;
    if (dvalid) begin
      valid_cnt++;
      if (valid_prev) dbl_valid++;
      if (expq.size() == 0) begin
        chk("R9 unexpected valid", 1, 0);
      end else begin
        logic [15:0] it;
        it = expq.pop_front();
        chk("R9 data", dout, it[11:0]);
        chk("R10 channel", conv_chan, it[15:12]);
      end
    end
    valid_prev = dvalid;
  end

  // converter model: answers each request after a short latency
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        repeat (2) @(negedge clk);
        if (conv_req) begin
          conv_code = code_next;
          conv_done = 1'b1;
          expq.push_back({cur_chan, code_next});
          @(negedge clk);
          conv_done = 1'b0;
          code_next = code_next * 12'd5 + 12'd13;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 req", conv_req, 0);
    chk("R1 valid", dvalid, 0);
    chk("R1 settled", settled, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single step: P=4, settle 8 ticks, wait 4 ticks
    mode = 2'd1; div = 6'd1; fast = 0; settle = 3'd0; long_wait = 0;
    chan = 4'd2; cur_chan = 4'd2; en = 1; c0 = cyc;
    repeat (32) @(negedge clk);
    chk("R3 settled low before end", settled, 0);
    @(negedge clk);
    chk("R3 settled after 8 ticks", settled, 1);
    wait_rises(1);
    chk("R4 first request timing", last_rise - c0, 1 + 4 * 13);
    chk("R2 tick spacing div=1", tick_gap, 4);
    chk("R10 digital chan 2", conv_digital, 1);
    repeat (300) @(negedge clk);
    chk("R6 one conversion", rises, 1);
    chk("R6 busy low after", busy, 0);
    chk("R9 one valid", valid_cnt, 1);

    // free running, divider bypass, long wait
    en = 0;
    @(negedge clk);
    mode = 2'd3; fast = 1; div = 6'd63; settle = 3'd1; long_wait = 1;
    rate = 6'd2; chan = 4'd9; cur_chan = 4'd9; en = 1; c0 = cyc; base = rises;
    wait_rises(base + 1);
    chk("R4 first request fast long", last_rise - c0, 1 + (16 + 1 + 8));
    wait_rises(base + 3);
    chk("R5 period 18 ticks", last_rise - prev_rise, 18);
    chk("R2 bypass tick every cycle", tick_gap, 1);
    chk("R10 analog chan 9", conv_digital, 0);

    // abort during acquisition by enable
    wait_acq();
    en = 0;
    base = valid_cnt;
    @(negedge clk);
    chk("R11 busy cleared", busy, 0);
    chk("R11 req cleared", conv_req, 0);
    chk("R11 settled cleared", settled, 0);
    repeat (40) @(negedge clk);
    chk("R11 no valid after abort", valid_cnt, base);
    en = 1; c0 = cyc; base = rises;
    wait_rises(base + 1);
    chk("R11 settle restarts", last_rise - c0, 1 + (16 + 1 + 8));

    // abort by power-down mode
    wait_acq();
    mode = 2'd0;
    @(negedge clk);
    chk("R11 power-down clears busy", busy, 0);
    repeat (20) @(negedge clk);
    chk("R11 power-down unsettled", settled, 0);

    // software mode
    mode = 2'd2; fast = 0; div = 6'd0; settle = 3'd0; long_wait = 0;
    chan = 4'd3; cur_chan = 4'd3; base = rises;
    repeat (200) @(negedge clk);
    chk("R7 settled without start", settled, 1);
    chk("R7 no conversion without start", rises, base);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    wait_rises(base + 1);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    repeat (300) @(negedge clk);
    chk("R7 two conversions", rises, base + 2);
    chk("R10 digital chan 3", conv_digital, 1);

    chk("R8 req without busy", r8_bad, 0);
    chk("R9 double valid", dbl_valid, 0);
    chk("R9 scoreboard drained", expq.size(), 0);
    finish_run();
  end

endmodule